// File: doc/BRIEF.md
# Nibble-Serialized Register Access Port

This block is the device-side end of a byte-stream register interface, the kind that sits behind a USB-to-FIFO bridge. Each byte the host sends is one command. The upper nibble of the byte selects an operation and the lower nibble carries four bits of payload. Register addresses and write data are eight bits wide, so each of them arrives as two commands. The block assembles these nibbles, writes a 256-byte register file, and sends read results back as single bytes on an output stream that uses a valid/ready handshake.

Every data write and every incrementing read moves the address forward by one. A host can therefore set the address once and then stream several bytes in, or fetch a run of consecutive registers in one burst. For example, two 24-bit positions stored in six consecutive registers, each stored least significant byte first, come back through six incrementing reads. A value written high byte first lands with its high byte at the base address and its low byte at the next one.

Top module: `nibble_reg_port`

## Requirements
- R1: After reset the address pointer is 0, every register reads as 0x00, `rd_valid` is low and `cmd_ready` is high.
- R2: Command 0x0n replaces bits 3:0 of the address with n and leaves bits 7:4 unchanged.
- R3: Command 0x1n replaces bits 7:4 of the address with n and leaves bits 3:0 unchanged.
- R4: Command 0x2n stores n as a pending low data nibble and writes no register. The pending nibble stays held until the next 0x2n command.
- R5: Command 0x3n writes the byte {n, pending low nibble} into the register at the current address and then increments the address by one. The address wraps from 0xFF to 0x00.
- R6: Command 0x4x (x is ignored) places the currently addressed register on `rd_data`, with `rd_valid` high, in the cycle after it is accepted. It leaves the address unchanged.
- R7: Command 0x5x does what 0x4x does and then increments the address by one. Consecutive 0x5x commands return consecutive registers in ascending order, so a multi-byte value stored least significant byte first comes back low byte first.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` does not change.
- R9: While a returned byte is waiting (`rd_valid` high, `rd_ready` low), `cmd_ready` is low for read commands (0x4x, 0x5x) and high for every other command.
- R10: Commands whose upper nibble is 0x6 through 0xF change no register, leave the address unchanged and produce no output byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte accepted on this edge when valid |
| cmd_byte | input | 8 | Opcode in bits 7:4, payload nibble in bits 3:0 |
| rd_valid | output | 1 | Returned byte present |
| rd_ready | input | 1 | Consumer takes the returned byte |
| rd_data | output | 8 | Returned register content |

## Verification
The assertions cover the following on every cycle:
- the output holds under backpressure;
- read commands stall while a byte is pending;
- every accepted read produces an output byte;
- each opcode has the correct effect on the address pointer, including the increment after writes and incrementing reads and no change for undefined opcodes.

Only the directed scenarios can show the data path:
- that nibble pairs form the right byte;
- that burst writes land in consecutive registers;
- that a pending low nibble is not written on its own;
- that six incrementing reads rebuild two 24-bit values;
- that the address wraps from 0xFF to 0x00.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  parameter int NIB_W = 4;
  localparam int CMD_W  = 2 * NIB_W;
  localparam int ADDR_W = 2 * NIB_W;
  localparam int DATA_W = 2 * NIB_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO  = 4'h0,
    OP_ADDR_HI  = 4'h1,
    OP_DATA_LO  = 4'h2,
    OP_DATA_WR  = 4'h3,
    OP_READ     = 4'h4,
    OP_READ_INC = 4'h5
  } nrp_op_e;
endpackage

// File: rtl/nrp_decode.sv
module nrp_decode
  import nrp_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             out_busy,
  output logic             cmd_ready,
  output logic             set_lo,
  output logic             set_hi,
  output logic             latch_lo,
  output logic             wr_en,
  output logic             rd_en,
  output logic             rd_inc,
  output logic [NIB_W-1:0] nib
);
  logic [NIB_W-1:0] op;
  logic             is_rd;
  logic             fire;

  always_comb begin
    op        = cmd_byte[CMD_W-1 -: NIB_W];
    nib       = cmd_byte[NIB_W-1:0];
    is_rd     = (op == OP_READ) || (op == OP_READ_INC);
    cmd_ready = !(is_rd && out_busy);
    fire      = cmd_valid && cmd_ready;
    set_lo    = fire && (op == OP_ADDR_LO);
    set_hi    = fire && (op == OP_ADDR_HI);
    latch_lo  = fire && (op == OP_DATA_LO);
    wr_en     = fire && (op == OP_DATA_WR);
    rd_en     = fire && is_rd;
    rd_inc    = fire && (op == OP_READ_INC);
  end
endmodule

// File: rtl/nrp_regfile.sv
module nrp_regfile
  import nrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/nrp_rdout.sv
module nrp_rdout
  import nrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              valid_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = rd_valid;
    data_d  = rd_data;
    if (load) begin
      valid_d = 1'b1;
      data_d  = din;
    end else if (rd_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
  import nrp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_byte,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);
  logic              set_lo, set_hi, latch_lo, wr_en, rd_en, rd_inc;
  logic [NIB_W-1:0]  nib;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NIB_W-1:0]  lo_q, lo_d;
  logic [DATA_W-1:0] rf_rdata;
  logic              out_busy;

  assign out_busy = rd_valid && !rd_ready;

  nrp_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .out_busy  (out_busy),
    .cmd_ready (cmd_ready),
    .set_lo    (set_lo),
    .set_hi    (set_hi),
    .latch_lo  (latch_lo),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_inc    (rd_inc),
    .nib       (nib)
  );

  always_comb begin
    addr_d = addr_q;
    lo_d   = lo_q;
    if (set_lo)          addr_d[NIB_W-1:0]      = nib;
    if (set_hi)          addr_d[ADDR_W-1:NIB_W] = nib;
    if (wr_en || rd_inc) addr_d = addr_q + ADDR_W'(1);
    if (latch_lo)        lo_d = nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      addr_q <= addr_d;
      lo_q   <= lo_d;
    end
  end

  nrp_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .addr  (addr_q),
    .wdata ({nib, lo_q}),
    .rdata (rf_rdata)
  );

  nrp_rdout u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_en),
    .din      (rf_rdata),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/nrp_checker.sv
module nrp_checker
  import nrp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_byte,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] addr_q
);
  logic [NIB_W-1:0] opc;
  logic             acc;
  logic             rdcmd;
  assign opc   = cmd_byte[CMD_W-1 -: NIB_W];
  assign acc   = cmd_valid && cmd_ready;
  assign rdcmd = (opc == 4'h4) || (opc == 4'h5);

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r9_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && rdcmd && rd_valid && !rd_ready |-> !cmd_ready);

  a_r9_other_flow: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !rdcmd |-> cmd_ready);

  a_r6_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    acc && rdcmd |=> rd_valid);

  a_r6_read_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc == 4'h4 |=> $stable(addr_q));

  a_r7_read_inc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc == 4'h5 |=> addr_q == $past(addr_q) + ADDR_W'(1));

  a_r5_write_inc: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc == 4'h3 |=> addr_q == $past(addr_q) + ADDR_W'(1));

  a_r2_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc == 4'h0 |=> addr_q[NIB_W-1:0] == $past(cmd_byte[NIB_W-1:0])
                           && addr_q[ADDR_W-1:NIB_W] == $past(addr_q[ADDR_W-1:NIB_W]));

  a_r3_addr_high: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc == 4'h1 |=> addr_q[ADDR_W-1:NIB_W] == $past(cmd_byte[NIB_W-1:0])
                           && addr_q[NIB_W-1:0] == $past(addr_q[NIB_W-1:0]));

  a_r10_undefined: assert property (@(posedge clk) disable iff (!rst_n)
    acc && opc > 4'h5 |=> $stable(addr_q));
endmodule

bind nibble_reg_port nrp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_byte  (cmd_byte),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .addr_q    (addr_q)
);

// File: tb/tb_nibble_reg_port.sv
`timescale 1ns/100ps
module tb_nibble_reg_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_byte;
  logic       rd_valid;
  logic       rd_ready;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nibble_reg_port dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic wr_byte(input logic [7:0] d);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  task automatic rd_byte(input bit inc, output logic [7:0] v);
    send(inc ? 8'h5A : 8'h4C);
    chk("R6 rd_valid after read", rd_valid, 1'b1);
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rd_valid after reset", rd_valid, 1'b0);
    chk("R1 cmd_ready after reset", cmd_ready, 1'b1);
    rd_byte(0, v);
    chk("R1 register 0 at reset", v, 8'h00);
    set_addr(8'hFF);
    rd_byte(0, v);
    chk("R1 register FF at reset", v, 8'h00);
  endtask

  task automatic t_addr_nibbles;
    logic [7:0] v;
    set_addr(8'h3C);
    wr_byte(8'hA5);
    set_addr(8'h3C);
    rd_byte(0, v);
    chk("R5 byte A5 at 3C", v, 8'hA5);
    send(8'h01);
    rd_byte(0, v);
    chk("R2 low nibble only gives 31", v, 8'h00);
    send(8'h0C);
    rd_byte(0, v);
    chk("R2 back to 3C", v, 8'hA5);
    send(8'h15);
    send(8'h0C);
    wr_byte(8'h77);
    set_addr(8'h3C);
    rd_byte(0, v);
    chk("R3 high nibble keeps 3C intact", v, 8'hA5);
    set_addr(8'h5C);
    rd_byte(0, v);
    chk("R3 write reached 5C", v, 8'h77);
  endtask

  task automatic t_burst;
    logic [7:0] v;
    set_addr(8'h10);
    wr_byte(8'h11);
    wr_byte(8'h22);
    wr_byte(8'h33);
    set_addr(8'h10);
    rd_byte(1, v); chk("R7 burst byte 0", v, 8'h11);
    rd_byte(1, v); chk("R7 burst byte 1", v, 8'h22);
    rd_byte(1, v); chk("R7 burst byte 2", v, 8'h33);
    rd_byte(0, v); chk("R5 next register untouched", v, 8'h00);
  endtask

  task automatic t_low_pending;
    logic [7:0] v;
    set_addr(8'h50);
    send(8'h27);
    rd_byte(0, v);
    chk("R4 low nibble alone writes nothing", v, 8'h00);
    send(8'h38);
    set_addr(8'h50);
    rd_byte(0, v);
    chk("R4 held nibble used on write", v, 8'h87);
  endtask

  task automatic t_positions;
    logic [7:0]  v;
    logic [23:0] trg;
    logic [23:0] stp;
    set_addr(8'h20);
    wr_byte(8'h56); wr_byte(8'h34); wr_byte(8'h12);
    wr_byte(8'hEF); wr_byte(8'hCD); wr_byte(8'hAB);
    set_addr(8'h20);
    for (int i = 0; i < 3; i++) begin rd_byte(1, v); trg[8*i +: 8] = v; end
    for (int i = 0; i < 3; i++) begin rd_byte(1, v); stp[8*i +: 8] = v; end
    chk("R7 first 24-bit value", trg, 24'h123456);
    chk("R7 second 24-bit value", stp, 24'hABCDEF);
  endtask

  task automatic t_plain_read;
    logic [7:0] a;
    logic [7:0] b;
    set_addr(8'h21);
    rd_byte(0, a);
    rd_byte(0, b);
    chk("R6 repeated read same register", b, a);
    chk("R6 value at 21", a, 8'h34);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    set_addr(8'hFF);
    wr_byte(8'h5A);
    wr_byte(8'hC3);
    set_addr(8'hFF);
    rd_byte(1, v); chk("R5 byte at FF", v, 8'h5A);
    rd_byte(1, v); chk("R5 write wrapped to 00", v, 8'hC3);
  endtask

  task automatic t_backpressure;
    logic [7:0] held;
    set_addr(8'h12);
    rd_ready = 1'b0;
    send(8'h40);
    held = rd_data;
    chk("R8 byte presented", held, 8'h33);
    repeat (3) @(posedge clk);
    #1;
    chk("R8 valid held", rd_valid, 1'b1);
    chk("R8 data held", rd_data, held);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = 8'h51;
    #1;
    chk("R9 read stalled", cmd_ready, 1'b0);
    @(posedge clk);
    #1;
    chk("R9 stalled read leaves output", rd_data, held);
    @(negedge clk);
    cmd_byte = 8'h10;
    #1;
    chk("R9 non-read accepted", cmd_ready, 1'b1);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    rd_ready  = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 byte taken when ready", rd_valid, 1'b0);
  endtask

  task automatic t_undefined;
    logic [7:0] v;
    set_addr(8'h40);
    wr_byte(8'h9E);
    set_addr(8'h40);
    send(8'h6F);
    chk("R10 no output byte 6F", rd_valid, 1'b0);
    send(8'hA3);
    send(8'hFF);
    chk("R10 no output byte FF", rd_valid, 1'b0);
    rd_byte(1, v);
    chk("R10 address and register unchanged", v, 8'h9E);
    rd_byte(0, v);
    chk("R10 neighbour unchanged", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte = 8'h00;
    rd_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_addr_nibbles();
    t_burst();
    t_low_pending();
    t_positions();
    t_plain_read();
    t_wrap();
    t_backpressure();
    t_undefined();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule